// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a processor core leaves its instruction stream for an interrupt handler, and it drives the steps of that entry. One input is a non-maskable line. A parameterised set of maskable request lines sits beside it, ranked by fixed priority. The block also watches a strobe that marks the end of each instruction. When a request is pending and allowed, the sequencer waits for that strobe. At the strobe it snapshots the core's status word and return address. It then issues two stack-write beats, status first and address second. Next it clears its interrupt-enable flag. Finally it presents the handler vector together with a one-cycle jump strobe.

The enable flag is held inside the block. The core sets it with a one-cycle pulse, for example when it executes an enable instruction. The flag is shown on an output, and the sequencer clears it by itself on every entry. Maskable lines are level-sensitive and are gated by the flag. The non-maskable line is edge-triggered and ignores the flag. The stack memory, the return from a handler and any nesting scheme belong to the surrounding core.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, stk_we_o, jump_o, ie_o and vec_o are all 0.
- R2: Entry begins only on the cycle after a cycle in which insn_done_i was high while a pending, allowed request was already waiting. Without that strobe, no stack write and no jump occur, however long the request is held.
- R3: An entry produces exactly two consecutive stack writes. The first carries the status word: flags_i as it was at the boundary cycle, zero-extended to DATA_W, with bit IE_BIT (9 by default) replaced by the enable flag's value at that cycle. The second carries ret_addr_i as it was at the boundary cycle, zero-extended.
- R4: The cycle after the second write has no write and no jump. In the cycle after that, jump_o is high for exactly one cycle, with vec_o holding the vector and ie_o already 0.
- R5: While ie_o is 0, maskable request lines cause no entry.
- R6: The non-maskable line causes an entry whatever the state of ie_o.
- R7: Only a low-to-high transition of nmi_i makes a non-maskable request. Holding the line high afterwards causes no further entry.
- R8: Among allowed maskable requests, the lowest index wins, and its vector is IRQ_VEC_BASE + index (32 + index by default).
- R9: A pending non-maskable request outranks every maskable request and uses vector NMI_VEC (2 by default).
- R10: A request that arrives during an entry sequence stays pending and is taken only at a boundary strobe after that sequence has ended.
- R11: A maskable line that drops before the boundary strobe leaves nothing pending, and no entry follows.
- R12: A one-cycle pulse on ie_set_i drives ie_o to 1 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request line, active high, edge-triggered |
| irq_i | input | NUM_IRQ | Maskable request lines, active high, level-sensitive; index 0 has the highest priority |
| insn_done_i | input | 1 | Strobe marking the cycle in which the current instruction completes |
| ie_set_i | input | 1 | Pulse that sets the interrupt-enable flag |
| flags_i | input | FLAG_W | Core status word, saved on entry |
| ret_addr_i | input | ADDR_W | Return address, saved on entry |
| stk_we_o | output | 1 | Stack write strobe |
| stk_data_o | output | DATA_W | Stack write data |
| jump_o | output | 1 | One-cycle strobe telling the core to jump to the handler |
| vec_o | output | VEC_W | Handler vector number, valid while jump_o is high, 0 otherwise |
| ie_o | output | 1 | Current interrupt-enable flag |

## Verification
The bench builds the block with its default parameters: eight maskable lines, a 16-bit status word, 32-bit addresses and stack words, an 8-bit vector, the enable bit at position 9, the non-maskable vector at 2 and maskable vectors starting at 32. With these values, the top and bottom request indices and a mixed set of requests can be checked against exact vector numbers. The bench can also tell the enable bit apart in the saved status word. It changes flags_i and ret_addr_i straight after the boundary, which shows that the values were snapshotted. It raises the non-maskable line in the middle of an entry to confirm that the request is deferred.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   // Entry sequence states; the order is the order of the walk.
   typedef enum logic [2:0] {
      SEQ_IDLE   = 3'd0,
      SEQ_WAIT   = 3'd1,
      SEQ_SAVE_F = 3'd2,
      SEQ_SAVE_A = 3'd3,
      SEQ_DROP_E = 3'd4,
      SEQ_JUMP   = 3'd5
   } seq_state_t;

   // Width of an index into a set of n request lines.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_nmi_catch.sv
// Turns a rising edge on the non-maskable line into a held request.
module irq_nmi_catch (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic take_i,
   output logic pend_o
);
   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = line_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= line_i;
         // A fresh edge wins over the clear from an entry in the same cycle.
         pend_q <= rise | (pend_q & ~take_i);
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority pick: the lowest set index wins.
module irq_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = irq_entry_pkg::idx_width(N)
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   generate
      if (N == 1) begin : g_single
         assign any_o = req_i[0];
         assign idx_o = '0;
      end else begin : g_multi
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) begin
                  any_o = 1'b1;
                  idx_o = IDX_W'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_entry_snap.sv
// Holds what the sequence needs after the boundary: the two stack words,
// the vector and the kind of source that was taken.
module irq_entry_snap #(
   parameter int DATA_W = 32,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] flag_word_i,
   input  logic [DATA_W-1:0] addr_word_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic              nmi_i,
   output logic [DATA_W-1:0] flag_word_o,
   output logic [DATA_W-1:0] addr_word_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              nmi_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_word_o <= '0;
         addr_word_o <= '0;
         vec_o       <= '0;
         nmi_o       <= 1'b0;
      end else if (cap_i) begin
         flag_word_o <= flag_word_i;
         addr_word_o <= addr_word_i;
         vec_o       <= vec_i;
         nmi_o       <= nmi_i;
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int NUM_IRQ      = 8,
   parameter int FLAG_W       = 16,
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int VEC_W        = 8,
   parameter int NMI_VEC      = 2,
   parameter int IRQ_VEC_BASE = 32,
   parameter int IE_BIT       = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nmi_i,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               insn_done_i,
   input  logic               ie_set_i,
   input  logic [FLAG_W-1:0]  flags_i,
   input  logic [ADDR_W-1:0]  ret_addr_i,
   output logic               stk_we_o,
   output logic [DATA_W-1:0]  stk_data_o,
   output logic               jump_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               ie_o
);
   import irq_entry_pkg::*;

   localparam int IDX_W = idx_width(NUM_IRQ);
   localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
   localparam logic [VEC_W-1:0] BASE_V = VEC_W'(IRQ_VEC_BASE);

   // Elaboration-time parameter checks
   generate
      if (NUM_IRQ < 1) begin : g_bad_n
         $error("NUM_IRQ must be at least 1");
      end
      if (FLAG_W > DATA_W || ADDR_W > DATA_W) begin : g_bad_w
         $error("status word and address must fit in a stack word");
      end
      if (IE_BIT < 0 || IE_BIT >= FLAG_W) begin : g_bad_bit
         $error("IE_BIT must lie inside the status word");
      end
      if (IRQ_VEC_BASE + NUM_IRQ > (1 << VEC_W) || NMI_VEC >= (1 << VEC_W)) begin : g_bad_v
         $error("vectors do not fit in VEC_W bits");
      end
      if (NMI_VEC >= IRQ_VEC_BASE && NMI_VEC < IRQ_VEC_BASE + NUM_IRQ) begin : g_bad_ov
         $error("NMI_VEC overlaps the maskable vector range");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic              ie_q;
   logic              nmi_pend;
   logic              take_nmi;
   logic              capture;
   logic [NUM_IRQ-1:0] irq_allowed;
   logic              irq_any;
   logic [IDX_W-1:0]  irq_idx;
   logic              want;
   logic [DATA_W-1:0] flag_word;
   logic [VEC_W-1:0]  vec_pick;
   logic [DATA_W-1:0] flag_q;
   logic [DATA_W-1:0] addr_q;
   logic [VEC_W-1:0]  vec_q;
   logic              src_nmi_q;

   irq_nmi_catch u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (nmi_i),
      .take_i (take_nmi),
      .pend_o (nmi_pend)
   );

   assign irq_allowed = ie_q ? irq_i : '0;

   irq_prio_pick #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
      .req_i (irq_allowed),
      .any_o (irq_any),
      .idx_o (irq_idx)
   );

   assign want     = nmi_pend | irq_any;
   assign capture  = (state_q == SEQ_WAIT) && want && insn_done_i;
   assign take_nmi = capture & nmi_pend;
   assign vec_pick = nmi_pend ? NMI_V : (BASE_V + VEC_W'(irq_idx));

   // Saved status word carries the enable flag at its fixed position.
   always_comb begin
      flag_word         = DATA_W'(flags_i);
      flag_word[IE_BIT] = ie_q;
   end

   irq_entry_snap #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_snap (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_i       (capture),
      .flag_word_i (flag_word),
      .addr_word_i (DATA_W'(ret_addr_i)),
      .vec_i       (vec_pick),
      .nmi_i       (nmi_pend),
      .flag_word_o (flag_q),
      .addr_word_o (addr_q),
      .vec_o       (vec_q),
      .nmi_o       (src_nmi_q)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE:   if (want) state_d = SEQ_WAIT;
         SEQ_WAIT: begin
            if (!want)            state_d = SEQ_IDLE;
            else if (insn_done_i) state_d = SEQ_SAVE_F;
         end
         SEQ_SAVE_F: state_d = SEQ_SAVE_A;
         SEQ_SAVE_A: state_d = SEQ_DROP_E;
         SEQ_DROP_E: state_d = SEQ_JUMP;
         SEQ_JUMP:   state_d = SEQ_IDLE;
         default:    state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         ie_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SEQ_DROP_E) ie_q <= 1'b0;
         else if (ie_set_i)         ie_q <= 1'b1;
      end
   end

   assign stk_we_o   = (state_q == SEQ_SAVE_F) || (state_q == SEQ_SAVE_A);
   assign stk_data_o = (state_q == SEQ_SAVE_F) ? flag_q :
                       (state_q == SEQ_SAVE_A) ? addr_q : '0;
   assign jump_o     = (state_q == SEQ_JUMP);
   assign vec_o      = jump_o ? vec_q : '0;
   assign ie_o       = ie_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int NUM_IRQ      = 8,
   parameter int VEC_W        = 8,
   parameter int NMI_VEC      = 2,
   parameter int IRQ_VEC_BASE = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             insn_done_i,
   input logic             stk_we_o,
   input logic             jump_o,
   input logic [VEC_W-1:0] vec_o,
   input logic             ie_o,
   input logic             src_nmi_q
);
   localparam logic [VEC_W-1:0] LO = VEC_W'(IRQ_VEC_BASE);
   localparam logic [VEC_W-1:0] HI = VEC_W'(IRQ_VEC_BASE + NUM_IRQ - 1);

   // R2
   first_write_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && !$past(stk_we_o)) |-> $past(insn_done_i));

   // R3
   write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && !$past(stk_we_o)) |=> stk_we_o);

   // R3
   write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && $past(stk_we_o)) |=> !stk_we_o);

   // R4
   jump_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jump_o |-> (!$past(stk_we_o) && $past(stk_we_o, 2)));

   // R4
   jump_enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jump_o |-> !ie_o);

   // R4
   jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jump_o |=> !jump_o);

   // R5
   masked_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_we_o && !$past(stk_we_o) && !$past(ie_o)) |-> src_nmi_q);

   // R8
   irq_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_o && !src_nmi_q) |-> (vec_o >= LO && vec_o <= HI));

   // R9
   nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_o && src_nmi_q) |-> (vec_o == VEC_W'(NMI_VEC)));

   // R4
   write_jump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_we_o, jump_o}));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
   .NUM_IRQ      (NUM_IRQ),
   .VEC_W        (VEC_W),
   .NMI_VEC      (NMI_VEC),
   .IRQ_VEC_BASE (IRQ_VEC_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .insn_done_i (insn_done_i),
   .stk_we_o    (stk_we_o),
   .jump_o      (jump_o),
   .vec_o       (vec_o),
   .ie_o        (ie_o),
   .src_nmi_q   (src_nmi_q)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_i = 1'b0;
   logic [7:0]  irq_i = '0;
   logic        insn_done_i = 1'b0;
   logic        ie_set_i = 1'b0;
   logic [15:0] flags_i = 16'h00A5;
   logic [31:0] ret_addr_i = 32'h1000_0040;
   logic        stk_we_o;
   logic [31:0] stk_data_o;
   logic        jump_o;
   logic [7:0]  vec_o;
   logic        ie_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_entry_seq uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .nmi_i       (nmi_i),
      .irq_i       (irq_i),
      .insn_done_i (insn_done_i),
      .ie_set_i    (ie_set_i),
      .flags_i     (flags_i),
      .ret_addr_i  (ret_addr_i),
      .stk_we_o    (stk_we_o),
      .stk_data_o  (stk_data_o),
      .jump_o      (jump_o),
      .vec_o       (vec_o),
      .ie_o        (ie_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_enable();
      @(negedge clk) ie_set_i = 1'b1;
      @(negedge clk) ie_set_i = 1'b0;
      check(ie_o == 1'b1, "R12", "ie after set pulse", ie_o, 1);
   endtask

   // Boundary strobes every other cycle; no write or jump may appear.
   task automatic quiet(input int n, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (stk_we_o || jump_o) bad++;
         insn_done_i = i[0];
      end
      @(negedge clk);
      if (stk_we_o || jump_o) bad++;
      insn_done_i = 1'b0;
      check(bad == 0, req, "cycles with write or jump", bad, 0);
   endtask

   // Sequencer is waiting; give a boundary and follow the entry.
   task automatic entry(input logic [7:0] exp_vec, input bit raise_nmi_mid,
                        input string req);
      logic [31:0] exp_f;
      logic [31:0] exp_a;
      logic        ie_before;
      logic [15:0] f_keep;
      logic [31:0] a_keep;
      f_keep    = flags_i;
      a_keep    = ret_addr_i;
      ie_before = ie_o;
      exp_f     = 32'(flags_i);
      exp_f[9]  = ie_before;
      exp_a     = ret_addr_i;
      check(!stk_we_o && !jump_o, "R2", "no activity before boundary",
            {stk_we_o, jump_o}, 0);
      @(negedge clk) insn_done_i = 1'b1;
      @(negedge clk) insn_done_i = 1'b0;
      flags_i    = ~f_keep;
      ret_addr_i = ~a_keep;
      check(stk_we_o && stk_data_o == exp_f, "R3", "first write (status)",
            {stk_we_o, stk_data_o}, {1'b1, exp_f});
      @(negedge clk);
      if (raise_nmi_mid) nmi_i = 1'b1;
      check(stk_we_o && stk_data_o == exp_a, "R3", "second write (address)",
            {stk_we_o, stk_data_o}, {1'b1, exp_a});
      @(negedge clk);
      check(!stk_we_o && !jump_o && ie_o == ie_before, "R4", "gap cycle",
            {stk_we_o, jump_o, ie_o}, {2'b00, ie_before});
      @(negedge clk);
      check(jump_o && !ie_o, "R4", "jump with enable cleared",
            {jump_o, ie_o}, 2'b10);
      check(vec_o == exp_vec, req, "vector", vec_o, exp_vec);
      @(negedge clk);
      check(!jump_o && vec_o == 0, "R4", "jump is one cycle", {jump_o, vec_o}, 0);
      flags_i    = f_keep;
      ret_addr_i = a_keep;
   endtask

   task automatic t_reset();
      check(!stk_we_o && !jump_o && !ie_o && vec_o == 0, "R1", "reset outputs",
            {stk_we_o, jump_o, ie_o, vec_o}, 0);
   endtask

   task automatic t_masked();
      irq_i[3] = 1'b1;
      quiet(10, "R5");
      pulse_enable();
      cycles(3);
      entry(8'd35, 1'b0, "R8");
      irq_i = '0;
   endtask

   task automatic t_priority();
      pulse_enable();
      irq_i = 8'b1010_0100;
      cycles(6);
      check(!stk_we_o && !jump_o, "R2", "held request without boundary",
            {stk_we_o, jump_o}, 0);
      entry(8'd34, 1'b0, "R8");
      irq_i[2] = 1'b0;
      pulse_enable();
      cycles(3);
      entry(8'd37, 1'b0, "R8");
      irq_i = '0;
   endtask

   task automatic t_nmi_masked();
      check(ie_o == 1'b0, "R6", "enable clear before nmi", ie_o, 0);
      nmi_i = 1'b1;
      cycles(3);
      entry(8'd2, 1'b0, "R6");
      quiet(10, "R7");
      nmi_i = 1'b0;
      cycles(2);
   endtask

   task automatic t_nmi_over_irq();
      pulse_enable();
      irq_i[0] = 1'b1;
      nmi_i    = 1'b1;
      cycles(3);
      entry(8'd2, 1'b0, "R9");
      quiet(6, "R5");
      pulse_enable();
      cycles(3);
      entry(8'd32, 1'b0, "R8");
      irq_i = '0;
      nmi_i = 1'b0;
      cycles(2);
   endtask

   task automatic t_pending_during_seq();
      pulse_enable();
      irq_i[6] = 1'b1;
      cycles(3);
      entry(8'd38, 1'b1, "R8");
      cycles(4);
      check(!stk_we_o && !jump_o, "R10", "deferred request waits for boundary",
            {stk_we_o, jump_o}, 0);
      entry(8'd2, 1'b0, "R10");
      irq_i = '0;
      nmi_i = 1'b0;
      cycles(2);
   endtask

   task automatic t_withdraw();
      pulse_enable();
      irq_i[1] = 1'b1;
      cycles(3);
      irq_i[1] = 1'b0;
      quiet(8, "R11");
      check(ie_o == 1'b1, "R11", "enable untouched without entry", ie_o, 1);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masked();
      t_priority();
      t_nmi_masked();
      t_nmi_over_irq();
      t_pending_during_seq();
      t_withdraw();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule